// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a logical address, given as a segment number and an offset, into a physical address by looking up a per-segment descriptor in an internal table RAM. Each descriptor holds a starting physical address, a segment length, a valid flag and three privilege flags: read, write and execute. A request also carries an access type. The block checks the segment number against a programmable segment count, checks the valid flag, checks the offset against the segment length, and checks the access type against the privilege flags. Only when every check passes does it add the offset to the descriptor's base.

Two configuration registers place and size the table. A start-index register gives the RAM row that holds descriptor 0. A segment-count register gives how many segments are legal. A load port writes descriptors into the RAM one row at a time. Each request is answered on a result strobe two clock edges after it is sampled. The response carries either a physical address with fault code 0, or a nonzero fault code with the address forced to 0. The block accepts one request per cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid_o is 0, the segment count is 0 (so every request faults with code 1) and every table row has its valid flag cleared.
- R2: A request sampled with req_valid_i high at rising edge k yields exactly one rsp_valid_o cycle after edge k+1. Back-to-back requests give back-to-back responses in order. When rsp_valid_o is 0, rsp_fault_o and rsp_paddr_o are 0.
- R3: A segment number greater than or equal to the programmed segment count gives fault code 3'd1.
- R4: A descriptor whose valid flag is 0 gives fault code 3'd2.
- R5: An offset greater than or equal to the descriptor's length gives fault code 3'd3. An offset equal to length minus one is accepted.
- R6: Access codes are read 2'd0, write 2'd1 and execute 2'd2. Each needs privilege bit 0, 1 or 2 of ld_perm_i respectively. Code 2'd3 is always refused. A refused access gives fault code 3'd4.
- R7: When several checks fail, the reported code follows this priority: segment range (1), then valid flag (2), then length (3), then privilege (4).
- R8: With no fault, rsp_fault_o is 3'd0 and rsp_paddr_o is the base plus the offset, modulo 2^PA_W.
- R9: The descriptor used is the RAM row (start index + segment number) modulo DEPTH.
- R10: On any fault, rsp_paddr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write the start-index and segment-count registers |
| cfg_start_i | input | IDX_W | RAM row holding descriptor 0 |
| cfg_count_i | input | SEG_W+1 | Number of legal segments |
| ld_we_i | input | 1 | Write one table row |
| ld_row_i | input | IDX_W | Row to write |
| ld_base_i | input | PA_W | Segment start physical address |
| ld_len_i | input | OFF_W+1 | Segment length |
| ld_vld_i | input | 1 | Descriptor valid flag |
| ld_perm_i | input | 3 | Privilege flags: bit0 read, bit1 write, bit2 execute |
| req_valid_i | input | 1 | Request strobe |
| req_seg_i | input | SEG_W | Segment number |
| req_off_i | input | OFF_W | Offset within segment |
| req_acc_i | input | 2 | Access type |
| rsp_valid_o | output | 1 | Result strobe |
| rsp_paddr_o | output | PA_W | Physical address, 0 on fault |
| rsp_fault_o | output | 3 | Fault code, 0 when the translation succeeds |

## Verification
The bench probes the length comparison on both sides of the edge: an offset of length minus one must pass and an offset equal to the length must fault. A design that compares with less-or-equal would let one byte past the segment through. Requests that fail several checks at once are used to pin down the fault priority. A swapped order would, for example, report a length fault for an invalid descriptor. Start-index values that wrap around the RAM and a base addition that wraps past 2^PA_W catch index arithmetic that is too wide or too narrow. A back-to-back burst exposes any mix-up between pipeline stages or a lost result strobe.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_BOUNDS  = 3'd3,
    FLT_PRIV    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_BAD = 2'd3
  } acc_e;

  localparam int unsigned PERM_RD = 0;
  localparam int unsigned PERM_WR = 1;
  localparam int unsigned PERM_EX = 2;
  localparam int unsigned PERM_W  = 3;

endpackage

// File: rtl/seg_tbl_ram.sv
module seg_tbl_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             wvld_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvld_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // payload without reset; valid flags cleared on reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      rvld_o <= 1'b0;
    end else begin
      if (we_i) vld_q[waddr_i] <= wvld_i;
      rvld_o <= vld_q[raddr_i];
    end
  end

  p_vld_cleared_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wvld_i) |=> !vld_q[$past(waddr_i)]);

endmodule

// File: rtl/seg_chk.sv
module seg_chk
  import seg_xlate_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 20
) (
  input  logic              seg_ok_i,
  input  logic              e_vld_i,
  input  logic [PERM_W-1:0] e_perm_i,
  input  logic [OFF_W:0]    e_len_i,
  input  logic [PA_W-1:0]   e_base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        acc_i,
  output fault_e            fault_o,
  output logic [PA_W-1:0]   paddr_o
);

  logic len_ok, perm_ok;
  logic [PA_W-1:0] sum;

  assign len_ok = {1'b0, off_i} < e_len_i;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_RD:  perm_ok = e_perm_i[PERM_RD];
      ACC_WR:  perm_ok = e_perm_i[PERM_WR];
      ACC_EX:  perm_ok = e_perm_i[PERM_EX];
      default: perm_ok = 1'b0;
    endcase
  end

  generate
    if (PA_W > OFF_W) begin : g_wide
      assign sum = e_base_i + {{(PA_W-OFF_W){1'b0}}, off_i};
    end else begin : g_narrow
      assign sum = e_base_i + off_i[PA_W-1:0];
    end
  endgenerate

  // fixed priority: range, valid, length, privilege
  always_comb begin
    fault_o = FLT_NONE;
    paddr_o = '0;
    if (!seg_ok_i)     fault_o = FLT_RANGE;
    else if (!e_vld_i) fault_o = FLT_INVALID;
    else if (!len_ok)  fault_o = FLT_BOUNDS;
    else if (!perm_ok) fault_o = FLT_PRIV;
    else               paddr_o = sum;
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W = 4,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 20,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = SEG_W + 1,
  localparam int unsigned DW    = PA_W + OFF_W + 1 + PERM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_start_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  input  logic             ld_we_i,
  input  logic [IDX_W-1:0] ld_row_i,
  input  logic [PA_W-1:0]  ld_base_i,
  input  logic [OFF_W:0]   ld_len_i,
  input  logic             ld_vld_i,
  input  logic [2:0]       ld_perm_i,
  input  logic             req_valid_i,
  input  logic [SEG_W-1:0] req_seg_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [1:0]       req_acc_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [2:0]       rsp_fault_o
);

  logic [IDX_W-1:0] start_q;
  logic [CNT_W-1:0] count_q;
  logic [IDX_W-1:0] seg_idx, rd_idx;
  logic             seg_ok;

  logic             s1_vld, s1_seg_ok;
  logic [OFF_W-1:0] s1_off;
  logic [1:0]       s1_acc;

  logic [DW-1:0]    e_data;
  logic             e_vld;
  fault_e           chk_fault;
  logic [PA_W-1:0]  chk_paddr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      count_q <= '0;
    end else if (cfg_we_i) begin
      start_q <= cfg_start_i;
      count_q <= cfg_count_i;
    end
  end

  generate
    if (SEG_W >= IDX_W) begin : g_seg_trunc
      assign seg_idx = req_seg_i[IDX_W-1:0];
    end else begin : g_seg_ext
      assign seg_idx = {{(IDX_W-SEG_W){1'b0}}, req_seg_i};
    end
  endgenerate

  assign rd_idx = start_q + seg_idx;
  assign seg_ok = {1'b0, req_seg_i} < count_q;

  seg_tbl_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ld_we_i),
    .waddr_i (ld_row_i),
    .wdata_i ({ld_perm_i, ld_len_i, ld_base_i}),
    .wvld_i  (ld_vld_i),
    .raddr_i (rd_idx),
    .rdata_o (e_data),
    .rvld_o  (e_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld    <= 1'b0;
      s1_seg_ok <= 1'b0;
      s1_off    <= '0;
      s1_acc    <= '0;
    end else begin
      s1_vld    <= req_valid_i;
      s1_seg_ok <= seg_ok;
      s1_off    <= req_off_i;
      s1_acc    <= req_acc_i;
    end
  end

  seg_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .seg_ok_i (s1_seg_ok),
    .e_vld_i  (e_vld),
    .e_perm_i (e_data[DW-1 -: PERM_W]),
    .e_len_i  (e_data[PA_W +: OFF_W+1]),
    .e_base_i (e_data[PA_W-1:0]),
    .off_i    (s1_off),
    .acc_i    (s1_acc),
    .fault_o  (chk_fault),
    .paddr_o  (chk_paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= '0;
    end else begin
      rsp_valid_o <= s1_vld;
      rsp_paddr_o <= s1_vld ? chk_paddr : '0;
      rsp_fault_o <= s1_vld ? chk_fault : FLT_NONE;
    end
  end

  p_req_stage_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> s1_vld);
  p_rsp_stage_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld |=> rsp_valid_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_fault_o == 3'd0 && rsp_paddr_o == '0));
  p_range_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && !s1_seg_ok) |=> rsp_fault_o == FLT_RANGE);
  p_invalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && s1_seg_ok && !e_vld) |=> rsp_fault_o == FLT_INVALID);
  p_fault_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 3'd0) |-> rsp_paddr_o == '0);

endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

  localparam int SEG_W = 4, OFF_W = 12, PA_W = 20, DEPTH = 16, IDX_W = 4;

  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0; logic [IDX_W-1:0] cfg_start = 0; logic [SEG_W:0] cfg_count = 0;
  logic ld_we = 0; logic [IDX_W-1:0] ld_row = 0; logic [PA_W-1:0] ld_base = 0;
  logic [OFF_W:0] ld_len = 0; logic ld_vld = 0; logic [2:0] ld_perm = 0;
  logic req_valid = 0; logic [SEG_W-1:0] req_seg = 0; logic [OFF_W-1:0] req_off = 0;
  logic [1:0] req_acc = 0;
  logic rsp_valid; logic [PA_W-1:0] rsp_paddr; logic [2:0] rsp_fault;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  seg_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_start_i(cfg_start), .cfg_count_i(cfg_count),
    .ld_we_i(ld_we), .ld_row_i(ld_row), .ld_base_i(ld_base), .ld_len_i(ld_len),
    .ld_vld_i(ld_vld), .ld_perm_i(ld_perm),
    .req_valid_i(req_valid), .req_seg_i(req_seg), .req_off_i(req_off), .req_acc_i(req_acc),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  task automatic check(string tag, logic ev, logic [2:0] ef, logic [PA_W-1:0] ep);
    checks++;
    if (rsp_valid !== ev || rsp_fault !== ef || rsp_paddr !== ep) begin
      errors++;
      $display("FAIL %s: got v=%0b f=%0d pa=%h, exp v=%0b f=%0d pa=%h",
               tag, rsp_valid, rsp_fault, rsp_paddr, ev, ef, ep);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; repeat (2) @(negedge clk); rst_ni = 1; @(negedge clk);
  endtask

  task automatic cfg(logic [IDX_W-1:0] s, logic [SEG_W:0] c);
    cfg_we = 1; cfg_start = s; cfg_count = c; @(negedge clk); cfg_we = 0;
  endtask

  task automatic load(logic [IDX_W-1:0] r, logic [PA_W-1:0] b, logic [OFF_W:0] l,
                      logic v, logic [2:0] p);
    ld_we = 1; ld_row = r; ld_base = b; ld_len = l; ld_vld = v; ld_perm = p;
    @(negedge clk); ld_we = 0;
  endtask

  task automatic xlate(string tag, logic [SEG_W-1:0] s, logic [OFF_W-1:0] o, logic [1:0] a,
                       logic [2:0] ef, logic [PA_W-1:0] ep);
    req_valid = 1; req_seg = s; req_off = o; req_acc = a;
    @(negedge clk); req_valid = 0;
    check({tag, " R2 mid"}, 1'b0, 3'd0, '0);
    @(negedge clk);
    check(tag, 1'b1, ef, ep);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 idle after reset", 1'b0, 3'd0, '0);
    xlate("R1 count zero", 4'd0, 12'd0, 2'd0, 3'd1, '0);
  endtask

  task automatic t_setup();
    cfg(4'd0, 5'd8);
    load(4'd3, 20'h12345, 13'h100, 1, 3'b001);
    load(4'd5, 20'h00000, 13'h000, 0, 3'b000);
    load(4'd7, 20'hFFFF0, 13'h040, 1, 3'b110);
    load(4'd12, 20'h00400, 13'h1000, 1, 3'b111);
    load(4'd0, 20'h08000, 13'h010, 1, 3'b100);
  endtask

  task automatic t_basic();
    xlate("R8 read ok", 4'd3, 12'h000, 2'd0, 3'd0, 20'h12345);
    xlate("R5 last byte", 4'd3, 12'h0FF, 2'd0, 3'd0, 20'h12444);
    xlate("R8 wrap add", 4'd7, 12'h020, 2'd1, 3'd0, 20'h00010);
    xlate("R6 exec ok", 4'd7, 12'h001, 2'd2, 3'd0, 20'hFFFF1);
  endtask

  task automatic t_faults();
    xlate("R5 at length", 4'd3, 12'h100, 2'd0, 3'd3, '0);
    xlate("R4 invalid", 4'd5, 12'h000, 2'd0, 3'd2, '0);
    xlate("R3 seg eq count", 4'd8, 12'h000, 2'd0, 3'd1, '0);
    xlate("R3 seg far", 4'd15, 12'h000, 2'd0, 3'd1, '0);
    xlate("R6 write denied", 4'd3, 12'h010, 2'd1, 3'd4, '0);
    xlate("R6 exec denied", 4'd3, 12'h010, 2'd2, 3'd4, '0);
    xlate("R6 code3 denied", 4'd12 - 4'd5, 12'h000, 2'd3, 3'd4, '0);
    xlate("R10 read denied", 4'd7, 12'h000, 2'd0, 3'd4, '0);
  endtask

  task automatic t_priority();
    xlate("R7 invalid over bounds", 4'd5, 12'hFFF, 2'd3, 3'd2, '0);
    xlate("R7 bounds over priv", 4'd3, 12'h200, 2'd1, 3'd3, '0);
    cfg(4'd0, 5'd8);
    xlate("R7 range over valid row", 4'd12, 12'h000, 2'd0, 3'd1, '0);
  endtask

  task automatic t_start();
    cfg(4'd10, 5'd4);
    xlate("R9 offset start", 4'd2, 12'h005, 2'd0, 3'd0, 20'h00405);
    xlate("R9 count limit", 4'd4, 12'h005, 2'd0, 3'd1, '0);
    cfg(4'd14, 5'd4);
    xlate("R9 index wrap", 4'd2, 12'h00F, 2'd2, 3'd0, 20'h0800F);
    xlate("R9 wrap bounds", 4'd2, 12'h010, 2'd2, 3'd3, '0);
  endtask

  task automatic t_burst();
    cfg(4'd0, 5'd8);
    req_valid = 1; req_seg = 4'd3; req_off = 12'h001; req_acc = 2'd0; @(negedge clk);
    req_seg = 4'd5; @(negedge clk);
    check("R2 burst first", 1'b1, 3'd0, 20'h12346);
    req_seg = 4'd7; req_off = 12'h002; req_acc = 2'd1; @(negedge clk);
    req_valid = 0;
    check("R2 burst second", 1'b1, 3'd2, '0);
    @(negedge clk);
    check("R2 burst third", 1'b1, 3'd0, 20'hFFFF2);
    @(negedge clk);
    check("R2 burst end", 1'b0, 3'd0, '0);
  endtask

  task automatic t_reset_clears();
    do_reset();
    cfg(4'd0, 5'd8);
    xlate("R1 valid flags cleared", 4'd3, 12'h000, 2'd0, 3'd2, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_setup();
    t_basic();
    t_faults();
    t_priority();
    t_start();
    t_burst();
    t_reset_clears();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule